// File: doc/BRIEF.md
# Segmented Transmit Bus Protocol Monitor

This block watches a transmit user bus that moves four segments per clock. It never drives the bus. Each segment has an enable, a start flag and an end flag. Segment 0 comes first in packet order and segment 3 comes last. The monitor also samples two outputs of the downstream sink: a ready flag and an overflow flag.

From these inputs the monitor tracks whether a packet is open. This state carries from one segment to the next and from one cycle to the next. It enforces four framing rules and three flow rules. Each broken rule produces two signals: a one-cycle pulse on its own bit, and a sticky bit that stays set until a clear or a reset. A summary flag is set when any sticky bit is set. A separate sticky request asks for the sink to be reset once overflow has been seen.

All outputs are registered. A violation in cycle N appears at the ports in cycle N+1. The block is meant to sit next to a transmit client during integration, where it catches framing and flow-control misuse at the point where it happens.

Top module: `seg_bus_checker`

## Requirements
- R1: After reset every output is 0. The pulse for a cycle appears one clock after that cycle. A well-formed packet (start on one segment, no gaps, end on a later or the same segment) raises no pulse bit.
- R2: Pulse bit 0 is set for a cycle in which two or more enabled segments carry the start flag.
- R3: Pulse bit 1 is set when an enabled start segment arrives while a packet is open. The open packet may have started in an earlier cycle or in an earlier segment of the same cycle.
- R4: Pulse bit 2 is set for a cycle with no enabled segment when a packet is open at the start of the cycle and ready is 1. The same idle cycle with ready at 0 raises no pulse bit.
- R5: Pulse bit 3 is set when a cycle has at least one enabled segment and also has a disabled segment at a point where a packet is open. Segments are walked from 0 to 3.
- R6: Pulse bit 4 is set when an enabled segment without the start flag arrives while no packet is open. A single segment that carries both start and end leaves the packet closed.
- R7: A count tracks consecutive cycles with ready at 0. It saturates, and it returns to zero on any cycle with ready at 1. Pulse bit 5 is set for a cycle that has an enabled segment and is the fifth or later such cycle in a row.
- R8: Pulse bit 6 is set for any cycle that has an enabled segment while overflow is 1.
- R9: The reset-request output is set one clock after overflow is seen at 1. It then stays set until a clear or a reset.
- R10: Each sticky bit is set by its pulse. A clear input empties all sticky bits, the summary and the reset request on the next clock, and it wins over new events in the same cycle. The summary equals the OR of the sticky bits.
- R11: The start and end flags of a disabled segment are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Synchronous clear of the sticky status |
| tx_ena | input | NUM_SEG | Per-segment enable; bit i is segment i |
| tx_sop | input | NUM_SEG | Per-segment start-of-packet flag |
| tx_eop | input | NUM_SEG | Per-segment end-of-packet flag |
| sink_ready | input | 1 | Ready output of the downstream sink |
| sink_ovf | input | 1 | Overflow output of the downstream sink |
| err_pulse | output | 7 | One-cycle violation pulse per rule (bits 0 to 6 as in R2 to R8) |
| err_sticky | output | 7 | Sticky violation bit per rule |
| err_any | output | 1 | Summary of all sticky bits |
| sink_reset_req | output | 1 | Sticky request to reset the sink after overflow |

## Verification
A wrong open-packet state has no output of its own. It shows up one clock later as an error pulse on a well-formed packet, such as a false out-of-packet data pulse or a false start-inside-packet pulse. It can also show up as a missing pulse on a broken packet. A wrong not-ready count shows up as the late-transfer bit appearing one cycle early or late within a run of stalled cycles. A stuck or leaking sticky register shows up as a mismatch between the sticky bits and the summary flag on the next clock.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;

    localparam int NUM_RULES = 7;

    // bit positions in the pulse and sticky vectors
    typedef enum int unsigned {
        RULE_MULTI_SOP  = 0,
        RULE_SOP_OPEN   = 1,
        RULE_IDLE_CYC   = 2,
        RULE_IDLE_GAP   = 3,
        RULE_ORPHAN     = 4,
        RULE_LATE_XFER  = 5,
        RULE_OVF_XFER   = 6
    } rule_e;

    typedef logic [NUM_RULES-1:0] rule_vec_t;

    // classification of one segment after enable qualification
    typedef struct packed {
        logic act;
        logic start;
        logic fin;
    } seg_t;

    typedef struct packed {
        logic multi_sop;
        logic sop_open;
        logic idle_gap;
        logic orphan;
    } frame_viol_t;

    typedef struct packed {
        logic idle_cyc;
        logic late_xfer;
        logic ovf_xfer;
    } flow_viol_t;

    function automatic rule_vec_t pack_rules(frame_viol_t f, flow_viol_t w);
        rule_vec_t v;
        v = '0;
        v[RULE_MULTI_SOP] = f.multi_sop;
        v[RULE_SOP_OPEN]  = f.sop_open;
        v[RULE_IDLE_CYC]  = w.idle_cyc;
        v[RULE_IDLE_GAP]  = f.idle_gap;
        v[RULE_ORPHAN]    = f.orphan;
        v[RULE_LATE_XFER] = w.late_xfer;
        v[RULE_OVF_XFER]  = w.ovf_xfer;
        return v;
    endfunction

endpackage

// File: rtl/seg_chk_frame.sv
module seg_chk_frame
    import seg_chk_pkg::*;
#(
    parameter int NUM_SEG = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SEG-1:0] seg_ena,
    input  logic [NUM_SEG-1:0] seg_sop,
    input  logic [NUM_SEG-1:0] seg_eop,
    output frame_viol_t        viol,
    output logic               open_at_start,
    output logic               any_active
);

    seg_t               seg [NUM_SEG];
    logic [NUM_SEG-1:0] start_v;
    logic               open_q;
    logic               open_w;
    logic               sop_open_w;
    logic               orphan_w;
    logic               gap_w;

    // disabled segments lose their flags here (R11)
    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        assign seg[g].act   = seg_ena[g];
        assign seg[g].start = seg_ena[g] & seg_sop[g];
        assign seg[g].fin   = seg_ena[g] & seg_eop[g];
        assign start_v[g]   = seg_ena[g] & seg_sop[g];
    end

    // walk segments in packet order, earliest first
    always_comb begin
        open_w     = open_q;
        sop_open_w = 1'b0;
        orphan_w   = 1'b0;
        gap_w      = 1'b0;
        for (int i = 0; i < NUM_SEG; i++) begin
            if (seg[i].act) begin
                if (seg[i].start) begin
                    sop_open_w = sop_open_w | open_w;
                    open_w     = 1'b1;
                end else if (!open_w) begin
                    orphan_w = 1'b1;
                end
                if (seg[i].fin) begin
                    open_w = 1'b0;
                end
            end else if (open_w) begin
                gap_w = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
        end else begin
            open_q <= open_w;
        end
    end

    assign any_active     = |seg_ena;
    assign open_at_start  = open_q;
    assign viol.multi_sop = ($countones(start_v) > 1);
    assign viol.sop_open  = sop_open_w;
    assign viol.idle_gap  = gap_w & any_active;
    assign viol.orphan    = orphan_w;

endmodule

// File: rtl/seg_chk_flow.sv
module seg_chk_flow
    import seg_chk_pkg::*;
#(
    parameter int STALL_LIMIT = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ready,
    input  logic       ovf,
    input  logic       any_active,
    input  logic       open_at_start,
    output flow_viol_t viol
);

    localparam int              CNT_W   = $clog2(STALL_LIMIT + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(STALL_LIMIT);
    localparam logic [CNT_W-1:0] LATE_AT = CNT_W'(STALL_LIMIT - 1);

    // consecutive not-ready cycles before the current one
    logic [CNT_W-1:0] stall_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stall_q <= '0;
        end else if (ready) begin
            stall_q <= '0;
        end else if (stall_q != CNT_MAX) begin
            stall_q <= stall_q + 1'b1;
        end
    end

    assign viol.idle_cyc  = open_at_start & ready & ~any_active;
    assign viol.late_xfer = any_active & ~ready & (stall_q >= LATE_AT);
    assign viol.ovf_xfer  = any_active & ovf;

endmodule

// File: rtl/seg_chk_status.sv
module seg_chk_status
    import seg_chk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clear,
    input  rule_vec_t viol,
    input  logic      ovf,
    output rule_vec_t pulse_q,
    output rule_vec_t sticky_q,
    output logic      summary_q,
    output logic      rst_req_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_q   <= '0;
            sticky_q  <= '0;
            summary_q <= 1'b0;
            rst_req_q <= 1'b0;
        end else begin
            pulse_q <= viol;
            if (clear) begin
                sticky_q  <= '0;
                summary_q <= 1'b0;
                rst_req_q <= 1'b0;
            end else begin
                sticky_q  <= sticky_q | viol;
                summary_q <= summary_q | (|viol);
                rst_req_q <= rst_req_q | ovf;
            end
        end
    end

endmodule

// File: rtl/seg_bus_checker.sv
module seg_bus_checker
    import seg_chk_pkg::*;
#(
    parameter int NUM_SEG     = 4,
    parameter int STALL_LIMIT = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clear,
    input  logic [NUM_SEG-1:0]   tx_ena,
    input  logic [NUM_SEG-1:0]   tx_sop,
    input  logic [NUM_SEG-1:0]   tx_eop,
    input  logic                 sink_ready,
    input  logic                 sink_ovf,
    output logic [NUM_RULES-1:0] err_pulse,
    output logic [NUM_RULES-1:0] err_sticky,
    output logic                 err_any,
    output logic                 sink_reset_req
);

    frame_viol_t frame_v;
    flow_viol_t  flow_v;
    logic        open_at_start;
    logic        any_active;
    rule_vec_t   all_v;
    rule_vec_t   pulse_w;
    rule_vec_t   sticky_w;

    seg_chk_frame #(.NUM_SEG(NUM_SEG)) u_frame (
        .clk           (clk),
        .rst           (rst),
        .seg_ena       (tx_ena),
        .seg_sop       (tx_sop),
        .seg_eop       (tx_eop),
        .viol          (frame_v),
        .open_at_start (open_at_start),
        .any_active    (any_active)
    );

    seg_chk_flow #(.STALL_LIMIT(STALL_LIMIT)) u_flow (
        .clk           (clk),
        .rst           (rst),
        .ready         (sink_ready),
        .ovf           (sink_ovf),
        .any_active    (any_active),
        .open_at_start (open_at_start),
        .viol          (flow_v)
    );

    assign all_v = pack_rules(frame_v, flow_v);

    seg_chk_status u_status (
        .clk       (clk),
        .rst       (rst),
        .clear     (clear),
        .viol      (all_v),
        .ovf       (sink_ovf),
        .pulse_q   (pulse_w),
        .sticky_q  (sticky_w),
        .summary_q (err_any),
        .rst_req_q (sink_reset_req)
    );

    assign err_pulse  = pulse_w;
    assign err_sticky = sticky_w;

endmodule

// File: rtl/seg_bus_checker_sva.sv
module seg_bus_checker_sva
    import seg_chk_pkg::*;
#(
    parameter int NUM_SEG     = 4,
    parameter int STALL_LIMIT = 5
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 clear,
    input logic [NUM_SEG-1:0]   tx_ena,
    input logic [NUM_SEG-1:0]   tx_sop,
    input logic [NUM_SEG-1:0]   tx_eop,
    input logic                 sink_ready,
    input logic                 sink_ovf,
    input logic [NUM_RULES-1:0] err_pulse,
    input logic [NUM_RULES-1:0] err_sticky,
    input logic                 err_any,
    input logic                 sink_reset_req
);

    AST_MULTI_START: assert property (@(posedge clk) disable iff (rst)
        $countones(tx_ena & tx_sop) > 1 |=> err_pulse[RULE_MULTI_SOP]);  // R2

    AST_NO_LATE_WHEN_READY: assert property (@(posedge clk) disable iff (rst)
        sink_ready |=> !err_pulse[RULE_LATE_XFER]);  // R7

    AST_OVF_TRANSFER: assert property (@(posedge clk) disable iff (rst)
        (sink_ovf && (|tx_ena)) |=> err_pulse[RULE_OVF_XFER]);  // R8

    AST_RESET_REQUEST: assert property (@(posedge clk) disable iff (rst)
        (sink_ovf && !clear) |=> sink_reset_req);  // R9

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        clear |=> (err_sticky == '0) && !err_any && !sink_reset_req);  // R10

    AST_SUMMARY_MATCH: assert property (@(posedge clk) disable iff (rst)
        err_any == (|err_sticky));  // R10

    AST_PULSE_IN_STICKY: assert property (@(posedge clk) disable iff (rst)
        !$past(clear) |-> ((err_pulse & ~err_sticky) == '0));  // R10

endmodule

bind seg_bus_checker seg_bus_checker_sva #(
    .NUM_SEG     (NUM_SEG),
    .STALL_LIMIT (STALL_LIMIT)
) u_sva (
    .clk            (clk),
    .rst            (rst),
    .clear          (clear),
    .tx_ena         (tx_ena),
    .tx_sop         (tx_sop),
    .tx_eop         (tx_eop),
    .sink_ready     (sink_ready),
    .sink_ovf       (sink_ovf),
    .err_pulse      (err_pulse),
    .err_sticky     (err_sticky),
    .err_any        (err_any),
    .sink_reset_req (sink_reset_req)
);

// File: tb/seg_bus_checker_test.sv
module seg_bus_checker_test;

    localparam int CLK_PERIOD = 10;
    localparam int NS         = 4;
    localparam int NR         = 7;
    localparam int LIMIT      = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          clear = 1'b0;
    logic [NS-1:0] tx_ena = '0;
    logic [NS-1:0] tx_sop = '0;
    logic [NS-1:0] tx_eop = '0;
    logic          sink_ready = 1'b0;
    logic          sink_ovf = 1'b0;
    logic [NR-1:0] err_pulse;
    logic [NR-1:0] err_sticky;
    logic          err_any;
    logic          sink_reset_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // expected state
    bit          m_open;
    int          m_cnt;
    bit [NR-1:0] m_pulse;
    bit [NR-1:0] m_sticky;
    bit          m_any;
    bit          m_rreq;

    string tags [NR] = '{"R2", "R3", "R4", "R5", "R6", "R7", "R8"};

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_bus_checker uut (
        .clk            (clk),
        .rst            (rst),
        .clear          (clear),
        .tx_ena         (tx_ena),
        .tx_sop         (tx_sop),
        .tx_eop         (tx_eop),
        .sink_ready     (sink_ready),
        .sink_ovf       (sink_ovf),
        .err_pulse      (err_pulse),
        .err_sticky     (err_sticky),
        .err_any        (err_any),
        .sink_reset_req (sink_reset_req)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // rule vector predicted from the requirements
    function automatic bit [NR-1:0] predict(input bit [NS-1:0] e, s, p, input bit r, o,
                                            input bit open_in, input int cnt,
                                            output bit open_out);
        bit [NR-1:0] v = '0;
        bit op = open_in;
        bit gap = 1'b0;
        int starts = 0;
        for (int i = 0; i < NS; i++) begin
            if (!e[i]) begin
                if (op) gap = 1'b1;
                continue;
            end
            if (s[i]) begin
                starts++;
                if (op) v[1] = 1'b1;
                op = 1'b1;
            end else if (!op) begin
                v[4] = 1'b1;
            end
            if (p[i]) op = 1'b0;
        end
        v[0] = (starts >= 2);
        v[2] = open_in && r && (e == '0);
        v[3] = gap && (e != '0);
        v[5] = (e != '0) && !r && (cnt + 1 >= LIMIT);
        v[6] = (e != '0) && o;
        open_out = op;
        return v;
    endfunction

    task automatic compare_all();
        for (int i = 0; i < NR; i++)
            chk(err_pulse[i] == m_pulse[i], tags[i], err_pulse[i], m_pulse[i]);
        chk(err_sticky == m_sticky, "R10", err_sticky, m_sticky);
        chk(err_any == m_any, "R10", err_any, m_any);
        chk(sink_reset_req == m_rreq, "R9", sink_reset_req, m_rreq);
    endtask

    // drive one cycle at a falling edge, check at the next falling edge
    task automatic step(input bit [NS-1:0] e, s, p, input bit r, o, c);
        bit [NR-1:0] v;
        bit nopen;
        tx_ena = e; tx_sop = s; tx_eop = p;
        sink_ready = r; sink_ovf = o; clear = c;
        v = predict(e, s, p, r, o, m_open, m_cnt, nopen);
        m_open  = nopen;
        m_cnt   = r ? 0 : ((m_cnt < LIMIT) ? m_cnt + 1 : LIMIT);
        m_pulse = v;
        m_sticky = c ? '0 : (m_sticky | v);
        m_any    = c ? 1'b0 : (m_any | (|v));
        m_rreq   = c ? 1'b0 : (m_rreq | o);
        @(negedge clk);
        compare_all();
    endtask

    task automatic expect_pulse(input bit [NR-1:0] exp, input string tag);
        chk(err_pulse == exp, tag, err_pulse, exp);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        m_open = 0; m_cnt = 0; m_pulse = '0; m_sticky = '0; m_any = 0; m_rreq = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(err_pulse == '0 && err_sticky == '0 && !err_any && !sink_reset_req,
            "R1", {err_pulse, err_sticky, err_any, sink_reset_req}, 0);
        rst = 1'b0;

        // R1: well-formed packet across all segments
        step(4'b1111, 4'b0001, 4'b1000, 1, 0, 0);
        expect_pulse(7'b0000000, "R1");
        // R2: two starts in one cycle, leaves a packet open
        step(4'b1111, 4'b0101, 4'b0010, 1, 0, 0);
        expect_pulse(7'b0000001, "R2");
        // R4: idle while open and ready
        step(4'b0000, 4'b0000, 4'b0000, 1, 0, 0);
        expect_pulse(7'b0000100, "R4");
        // R4: idle while open but not ready is allowed
        step(4'b0000, 4'b0000, 4'b0000, 0, 0, 0);
        expect_pulse(7'b0000000, "R4");
        // R3: start while previous packet still open; closes at segment 3
        step(4'b1111, 4'b0001, 4'b1000, 1, 0, 0);
        expect_pulse(7'b0000010, "R3");
        // R3: start inside the same cycle after an unclosed start
        step(4'b1111, 4'b0101, 4'b1000, 1, 0, 0);
        expect_pulse(7'b0000011, "R3");
        // R6: one-segment packet leaves the bus closed, then data is orphan
        step(4'b0001, 4'b0001, 4'b0001, 1, 0, 0);
        expect_pulse(7'b0000000, "R6");
        step(4'b0001, 4'b0000, 4'b0000, 1, 0, 0);
        expect_pulse(7'b0010000, "R6");
        // R5: idle segment between start and end
        step(4'b1011, 4'b0001, 4'b1000, 1, 0, 0);
        expect_pulse(7'b0001000, "R5");
        // R11: flags on disabled segments are ignored
        step(4'b0000, 4'b1111, 4'b1111, 1, 0, 0);
        expect_pulse(7'b0000000, "R11");
        step(4'b0001, 4'b0001, 4'b0001, 1, 0, 0);
        expect_pulse(7'b0000000, "R11");
        // R7: four stalled transfers tolerated, fifth flagged
        step(4'b1111, 4'b0001, 4'b0000, 0, 0, 0);
        for (int k = 0; k < 3; k++) step(4'b1111, 4'b0000, 4'b0000, 0, 0, 0);
        expect_pulse(7'b0000000, "R7");
        step(4'b1111, 4'b0000, 4'b0000, 0, 0, 0);
        expect_pulse(7'b0100000, "R7");
        step(4'b1111, 4'b0000, 4'b1000, 1, 0, 0);
        expect_pulse(7'b0000000, "R7");
        step(4'b0001, 4'b0001, 4'b0001, 0, 0, 0);
        expect_pulse(7'b0000000, "R7");
        // R8 / R9: transfer under overflow, reset request latches
        step(4'b0001, 4'b0001, 4'b0001, 1, 1, 0);
        expect_pulse(7'b1000000, "R8");
        chk(sink_reset_req == 1'b1, "R9", sink_reset_req, 1);
        step(4'b0000, 4'b0000, 4'b0000, 1, 0, 0);
        chk(sink_reset_req == 1'b1, "R9", sink_reset_req, 1);
        // R10: clear wins over a new violation
        step(4'b0001, 4'b0000, 4'b0000, 1, 0, 1);
        chk(err_sticky == '0 && !err_any && !sink_reset_req, "R10",
            {err_sticky, err_any, sink_reset_req}, 0);
        expect_pulse(7'b0010000, "R10");

        // random traffic
        for (int n = 0; n < 4000; n++) begin
            bit [NS-1:0] e, s, p;
            for (int i = 0; i < NS; i++) begin
                e[i] = ($urandom_range(99) < 75);
                s[i] = ($urandom_range(99) < 15);
                p[i] = ($urandom_range(99) < 25);
            end
            if ($urandom_range(99) < 10) e = '0;
            step(e, s, p, ($urandom_range(99) < 70), ($urandom_range(99) < 3),
                 ($urandom_range(99) < 4));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule